// File: doc/BRIEF.md
# Interrupt Cause and Moderation Unit

This block gathers interrupt causes from the rest of a network controller and drives one interrupt line toward the CPU. Each cause has a bit in a pending register and a bit in a mask register. The line is raised only when an unmasked cause is pending and the moderation (throttle) interval allows it. Software reaches the three registers through a simple strobe bus. Reading the pending register returns its contents and clears it.

A cause is posted in one of two ways. A normal post waits for the throttle timer to run out. An immediate post bypasses the throttle timer. The unit also contains four delay timers, two for receive and two for transmit. When any of them expires it posts a fixed cause immediately. All timers count in 1024 ns ticks. A prescaler derives the tick from the core clock using the clock-period parameter. Once the line is high, it stays high until no unmasked cause remains.

Top module: `irq_moderator`

## Requirements
- R1: A post on `post_vld[i]` sets pending bit i at the next clock edge. Reading register select 0 (`reg_addr`=0) returns the pending bits in `reg_rdata[NCAUSE-1:0]` with upper bits zero. After reset the pending, mask (select 1) and throttle (select 2) registers all read zero, and `irq` is low.
- R2: `irq` is high only while at least one pending bit is also set in the mask. A pending bit whose mask bit is 0 leaves `irq` low.
- R3: A read strobe on select 0 returns the current pending value and clears every pending bit at that edge, and `irq` falls at the same edge. A post in the same cycle as the read survives the clear and is not part of the returned value.
- R4: A write to select 0 clears each pending bit whose `reg_wdata` bit is 1 and leaves the others. `irq` falls at that edge if no unmasked bit remains.
- R5: A write to select 1 loads the mask and re-evaluates at once. If a pending bit becomes unmasked, `irq` rises at the next edge even while the throttle interval is running. If no unmasked bit remains, `irq` falls at that edge.
- R6: Each rising edge of `irq` reloads the throttle counter with the select-2 value in ticks. While the counter is nonzero, a normal post does not raise `irq`. It rises within one cycle after the counter reaches zero.
- R7: A post with `post_now[i]` set, whose bit is unmasked, raises `irq` at the next edge regardless of the throttle counter.
- R8: A throttle value of 0 disables moderation, so every unmasked normal post raises `irq` at the next edge.
- R9: The receive packet-delay timer (reload `rx_pkt_dly`) restarts on every `rx_evt`. It expires `rx_pkt_dly` ticks after the last event and immediately posts pending bit RXDT_BIT (default 4).
- R10: The receive absolute-delay timer (reload `rx_abs_dly`) starts on an `rx_evt` only when it is idle. Later events do not restart it. On expiry it immediately posts bit RXDT_BIT.
- R11: The transmit idle-delay timer (`tx_idle_dly`, restarted by every `tx_evt`) and the transmit absolute-delay timer (`tx_abs_dly`, started only when idle) each immediately post bit TXDW_BIT (default 0) on expiry.
- R12: A delay timer whose reload value is 0 does not start, and its event posts nothing.
- R13: One timer tick lasts 1024 ns, which is 1024/CLK_NS core clocks. With the defaults that is 128 cycles at 8 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vld | input | NCAUSE | Cause post strobes, one per cause bit |
| post_now | input | NCAUSE | Immediate flag per posted bit (bypass throttle) |
| rx_evt | input | 1 | Receive event pulse feeding both receive delay timers |
| tx_evt | input | 1 | Transmit event pulse feeding both transmit delay timers |
| rx_pkt_dly | input | TMR_W | Receive packet-delay reload, ticks (0 = off) |
| rx_abs_dly | input | TMR_W | Receive absolute-delay reload, ticks (0 = off) |
| tx_idle_dly | input | TMR_W | Transmit idle-delay reload, ticks (0 = off) |
| tx_abs_dly | input | TMR_W | Transmit absolute-delay reload, ticks (0 = off) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on select 0) |
| reg_addr | input | 2 | Register select: 0 pending, 1 mask, 2 throttle |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, combinational from the selected register |
| irq | output | 1 | Interrupt line to the CPU, registered |

## Verification
A corrupted pending or mask bit shows on `irq` at the very next edge. It also appears in the value returned by the next read of select 0. A throttle counter that reloads wrong or counts down too slowly or too fast moves the rise of a normal post outside the window of one to two tick lengths after the previous rise. A delay timer that restarts when it should not, or fails to restart when it should, moves the posted cause by roughly the spacing between events. With events 200 cycles apart, that is well outside the tolerance of one tick.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;

   // Length of one moderation/delay tick in nanoseconds
   localparam int unsigned TICK_NS = 1024;

   // Register select codes on reg_addr
   typedef enum logic [1:0] {
      SEL_CAUSE    = 2'd0,
      SEL_MASK     = 2'd1,
      SEL_THROTTLE = 2'd2,
      SEL_NONE     = 2'd3
   } reg_sel_e;

   // Delay timer slots
   localparam int unsigned N_DLY   = 4;
   localparam int unsigned DLY_RXP = 0;  // receive packet delay (restarting)
   localparam int unsigned DLY_RXA = 1;  // receive absolute delay
   localparam int unsigned DLY_TXI = 2;  // transmit idle delay (restarting)
   localparam int unsigned DLY_TXA = 3;  // transmit absolute delay

endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen
   import irq_mod_pkg::*;
#(
   parameter int unsigned CLK_NS = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned DIV = TICK_NS / CLK_NS;
   localparam int unsigned CW  = (DIV > 1) ? $clog2(DIV) : 1;

   initial begin : p_param_chk
      assert (CLK_NS > 0 && CLK_NS <= TICK_NS && (TICK_NS % CLK_NS) == 0)
         else $error("irq_tick_gen: CLK_NS must divide %0d", TICK_NS);
   end

   generate
      if (DIV <= 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         logic [CW-1:0] cnt_q;
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);

         always_ff @(posedge clk) begin
            if (!rst_n)            cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == LAST);

         // R13: ticks are single-cycle pulses spaced DIV cycles apart
         a_r13_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
   parameter int unsigned CNT_W   = 16,
   parameter bit          RESTART = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             evt,
   input  logic [CNT_W-1:0] reload,
   output logic             expire
);
   initial begin : p_param_chk
      assert (CNT_W >= 1 && CNT_W <= 32)
         else $error("irq_delay_timer: CNT_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             may_start;
   logic             start;

   assign expire = run_q && tick && (cnt_q == CNT_W'(1));

   generate
      if (RESTART) begin : g_restart
         // every event reloads the count
         assign may_start = 1'b1;
      end else begin : g_absolute
         // only an idle (or just-expiring) timer accepts an event
         assign may_start = !run_q || expire;
      end
   endgenerate

   assign start = evt && (reload != '0) && may_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (start) begin
         cnt_q <= reload;
         run_q <= 1'b1;
      end else if (expire) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (run_q && tick) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   generate
      if (!RESTART) begin : g_abs_chk
         // R10: an event while running leaves the count untouched
         a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && evt && !tick) |=> (cnt_q == $past(cnt_q)));
      end
   endgenerate

   // R12: a zero reload never lets an idle timer start
   a_r12_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && evt && reload == '0) |=> !run_q);

endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] limit,
   output logic             ok
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= limit;
      else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign ok = (cnt_q == '0);

   // R8: a zero limit leaves moderation open after a reload
   a_r8_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (load && limit == '0) |=> ok);

   // R6: the count only falls on a tick
   a_r6_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
   import irq_mod_pkg::*;
#(
   parameter int unsigned NCAUSE   = 8,
   parameter int unsigned REG_W    = 16,
   parameter int unsigned TMR_W    = 16,
   parameter int unsigned THR_W    = 16,
   parameter int unsigned CLK_NS   = 8,
   parameter int unsigned RXDT_BIT = 4,
   parameter int unsigned TXDW_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCAUSE-1:0] post_vld,
   input  logic [NCAUSE-1:0] post_now,
   input  logic              rx_evt,
   input  logic              tx_evt,
   input  logic [TMR_W-1:0]  rx_pkt_dly,
   input  logic [TMR_W-1:0]  rx_abs_dly,
   input  logic [TMR_W-1:0]  tx_idle_dly,
   input  logic [TMR_W-1:0]  tx_abs_dly,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq
);
   initial begin : p_param_chk
      assert (NCAUSE >= 1 && NCAUSE <= REG_W)
         else $error("irq_moderator: NCAUSE must fit in REG_W");
      assert (THR_W >= 1 && THR_W <= REG_W)
         else $error("irq_moderator: THR_W must fit in REG_W");
      assert (RXDT_BIT < NCAUSE && TXDW_BIT < NCAUSE)
         else $error("irq_moderator: timer cause bits out of range");
   end

   // ---------------- time base ----------------
   logic tick;

   irq_tick_gen #(.CLK_NS(CLK_NS)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   // ---------------- delay timers ----------------
   logic [TMR_W-1:0] dly_reload [N_DLY];
   logic             dly_evt    [N_DLY];
   logic [N_DLY-1:0] dly_exp;

   assign dly_reload[DLY_RXP] = rx_pkt_dly;
   assign dly_reload[DLY_RXA] = rx_abs_dly;
   assign dly_reload[DLY_TXI] = tx_idle_dly;
   assign dly_reload[DLY_TXA] = tx_abs_dly;
   assign dly_evt[DLY_RXP]    = rx_evt;
   assign dly_evt[DLY_RXA]    = rx_evt;
   assign dly_evt[DLY_TXI]    = tx_evt;
   assign dly_evt[DLY_TXA]    = tx_evt;

   generate
      for (genvar t = 0; t < N_DLY; t++) begin : g_dly
         irq_delay_timer #(
            .CNT_W   (TMR_W),
            .RESTART ((t == DLY_RXP) || (t == DLY_TXI))
         ) u_dly (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .evt    (dly_evt[t]),
            .reload (dly_reload[t]),
            .expire (dly_exp[t])
         );
      end
   endgenerate

   logic rx_fire, tx_fire;
   assign rx_fire = dly_exp[DLY_RXP] | dly_exp[DLY_RXA];
   assign tx_fire = dly_exp[DLY_TXI] | dly_exp[DLY_TXA];

   // ---------------- register decode ----------------
   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_addr);

   logic rd_cause, wr_cause, wr_mask, wr_thr;
   assign rd_cause = reg_rd && (sel == SEL_CAUSE);
   assign wr_cause = reg_wr && (sel == SEL_CAUSE);
   assign wr_mask  = reg_wr && (sel == SEL_MASK);
   assign wr_thr   = reg_wr && (sel == SEL_THROTTLE);

   logic [NCAUSE-1:0] cause_q, mask_q;
   logic [THR_W-1:0]  thr_q;
   logic              irq_q;

   // ---------------- cause set / immediate vectors ----------------
   logic [NCAUSE-1:0] set_v, imm_v;

   always_comb begin
      set_v = post_vld;
      imm_v = post_vld & post_now;
      if (rx_fire) begin
         set_v[RXDT_BIT] = 1'b1;
         imm_v[RXDT_BIT] = 1'b1;
      end
      if (tx_fire) begin
         set_v[TXDW_BIT] = 1'b1;
         imm_v[TXDW_BIT] = 1'b1;
      end
   end

   // ---------------- next-state ----------------
   logic [NCAUSE-1:0] keep_v, cause_d, mask_d;
   logic              act, imm_hit, thr_ok, irq_d, irq_rise;

   always_comb begin
      if (rd_cause)      keep_v = '0;
      else if (wr_cause) keep_v = cause_q & ~reg_wdata[NCAUSE-1:0];
      else               keep_v = cause_q;
      cause_d = keep_v | set_v;
      mask_d  = wr_mask ? reg_wdata[NCAUSE-1:0] : mask_q;
   end

   assign act      = |(cause_d & mask_d);
   assign imm_hit  = (|(imm_v & mask_d)) | wr_mask;
   assign irq_d    = act && (irq_q || imm_hit || thr_ok);
   assign irq_rise = irq_d && !irq_q;

   irq_throttle #(.CNT_W(THR_W)) u_thr (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .load  (irq_rise),
      .limit (thr_q),
      .ok    (thr_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
         mask_q  <= '0;
         thr_q   <= '0;
         irq_q   <= 1'b0;
      end else begin
         cause_q <= cause_d;
         mask_q  <= mask_d;
         irq_q   <= irq_d;
         if (wr_thr) thr_q <= reg_wdata[THR_W-1:0];
      end
   end

   assign irq = irq_q;

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_CAUSE:    reg_rdata[NCAUSE-1:0] = cause_q;
         SEL_MASK:     reg_rdata[NCAUSE-1:0] = mask_q;
         SEL_THROTTLE: reg_rdata[THR_W-1:0]  = thr_q;
         SEL_NONE:     reg_rdata = '0;
      endcase
   end

   // ---------------- checks ----------------
   // R2: the line implies an unmasked pending cause
   a_r2_line_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> |(cause_q & mask_q));

   // R3: a read with no concurrent post empties the pending register
   a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cause && set_v == '0) |=> (cause_q == '0 && !irq_q));

   // R5: unmasking a pending cause raises the line without waiting
   a_r5_unmask_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask && |(cause_d & mask_d)) |=> irq_q);

   // R6: while the throttle runs, normal posts keep the line low
   a_r6_throttle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_q && !thr_ok && !(|(imm_v & mask_d)) && !wr_mask) |=> !irq_q);

   // R7: an unmasked immediate post raises the line next edge
   a_r7_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (|(imm_v & mask_d)) |=> irq_q);

endmodule

// File: tb/tb_irq_moderator.sv
module tb_irq_moderator;
   localparam int NC = 8;
   localparam int RW = 16;
   localparam int TW = 16;
   localparam int D  = 128;   // 1024 ns / 8 ns

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] post_vld = '0, post_now = '0;
   logic          rx_evt = 1'b0, tx_evt = 1'b0;
   logic [TW-1:0] rx_pkt_dly = '0, rx_abs_dly = '0, tx_idle_dly = '0, tx_abs_dly = '0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [RW-1:0] reg_wdata = '0;
   logic [RW-1:0] reg_rdata;
   logic          irq;

   always #4 clk = ~clk;   // 125 MHz

   irq_moderator dut (
      .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_now(post_now),
      .rx_evt(rx_evt), .tx_evt(tx_evt),
      .rx_pkt_dly(rx_pkt_dly), .rx_abs_dly(rx_abs_dly),
      .tx_idle_dly(tx_idle_dly), .tx_abs_dly(tx_abs_dly),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int            at;
      bit            is_data;
      logic [RW-1:0] val;
      string         tag;
   } exp_t;

   exp_t sb[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   // scoreboard push: check `val` on irq or reg_rdata `dly` cycles from now
   task automatic expect_at(input int dly, input bit is_data,
                            input logic [RW-1:0] val, input string tag);
      exp_t e;
      e.at = cyc + dly; e.is_data = is_data; e.val = val; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: samples 2 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
               logic [RW-1:0] act;
               act = sb[i].is_data ? reg_rdata : {{(RW-1){1'b0}}, irq};
               total++;
               if (act !== sb[i].val) begin
                  bad++;
                  $display("FAIL %s: actual=%h expected=%h (cycle %0d)",
                           sb[i].tag, act, sb[i].val, cyc);
               end
               sb.delete(i);
            end
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [RW-1:0] e, input string tag);
      reg_rd = 1'b1; reg_addr = a;
      expect_at(0, 1'b1, e, tag);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic post(input logic [NC-1:0] b, input bit now);
      post_vld = b; post_now = now ? b : '0;
      @(negedge clk);
      post_vld = '0; post_now = '0;
   endtask

   task automatic pulse_rx();
      rx_evt = 1'b1; @(negedge clk); rx_evt = 1'b0;
   endtask

   task automatic pulse_tx();
      tx_evt = 1'b1; @(negedge clk); tx_evt = 1'b0;
   endtask

   task automatic line(input bit v, input string tag);
      expect_at(0, 1'b0, RW'(v), tag);
      step(1);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int k, p;
      step(5);
      rst_n = 1'b1;
      step(1);

      // R1: reset state
      line(1'b0, "R1 reset irq");
      rd(2'd1, 16'h0000, "R1 reset mask");
      rd(2'd0, 16'h0000, "R1 reset pending");
      rd(2'd2, 16'h0000, "R1 reset throttle");

      wr(2'd2, 16'd0);
      wr(2'd1, 16'h0013);
      rd(2'd1, 16'h0013, "R5 mask readback");

      // R1 / R8: normal post, throttle off
      post(8'h02, 1'b0);
      line(1'b1, "R1 post raises line");
      rd(2'd0, 16'h0002, "R1 pending value");
      line(1'b0, "R3 read drops line");

      // R2: masked cause
      post(8'h08, 1'b0);
      line(1'b0, "R2 masked cause no line");
      step(3);
      line(1'b0, "R2 masked cause still low");
      rd(2'd0, 16'h0008, "R2 masked cause pending");

      // R3: post concurrent with read survives
      post(8'h01, 1'b0);
      reg_rd = 1'b1; reg_addr = 2'd0; post_vld = 8'h02;
      expect_at(0, 1'b1, 16'h0001, "R3 read returns old value");
      @(negedge clk);
      reg_rd = 1'b0; post_vld = '0;
      line(1'b1, "R3 concurrent post survives");
      rd(2'd0, 16'h0002, "R3 only new bit left");
      line(1'b0, "R3 line low after clear");

      // R4: write-one-to-clear
      post(8'h03, 1'b0);
      line(1'b1, "R4 two causes line high");
      wr(2'd0, 16'h0001);
      line(1'b1, "R4 partial clear keeps line");
      wr(2'd0, 16'h0002);
      line(1'b0, "R4 last clear drops line");
      rd(2'd0, 16'h0000, "R4 pending empty");

      // R8: zero throttle, back-to-back normal posts
      post(8'h02, 1'b0);
      rd(2'd0, 16'h0002, "R8 first pending");
      post(8'h02, 1'b0);
      line(1'b1, "R8 second post immediate");
      rd(2'd0, 16'h0002, "R8 second pending");

      // R6 / R7: throttle of 2 ticks
      wr(2'd2, 16'd2);
      rd(2'd2, 16'd2, "R6 throttle readback");
      post(8'h02, 1'b1);
      p = cyc;
      line(1'b1, "R7 immediate post raises");
      rd(2'd0, 16'h0002, "R6 clear after rise");
      post(8'h02, 1'b0);
      expect_at(0, 1'b0, 16'h0000, "R6 normal post held");
      expect_at(p + D - cyc, 1'b0, 16'h0000, "R6 held inside window");
      expect_at(p + 2 * D + 2 - cyc, 1'b0, 16'h0001, "R6 released after window/R13");
      wait_until(p + 2 * D + 4);
      rd(2'd0, 16'h0002, "R6 pending after release");
      post(8'h02, 1'b0);
      line(1'b0, "R6 throttle reloaded");
      post(8'h02, 1'b1);
      line(1'b1, "R7 bypass during throttle");
      rd(2'd0, 16'h0002, "R7 pending");

      // R5: mask write re-evaluation during throttle
      wr(2'd2, 16'd50);
      wr(2'd1, 16'h0002);
      post(8'h02, 1'b1);
      post(8'h04, 1'b0);
      rd(2'd0, 16'h0006, "R5 both pending");
      post(8'h04, 1'b0);
      line(1'b0, "R5 masked pending low");
      wr(2'd1, 16'h0004);
      line(1'b1, "R5 unmask raises at once");
      wr(2'd1, 16'h0000);
      line(1'b0, "R5 mask all drops");
      rd(2'd0, 16'h0004, "R5 pending kept");
      wr(2'd1, 16'h0013);
      wr(2'd2, 16'd0);

      // R9: restarting receive packet delay
      rx_pkt_dly = 16'd3; rx_abs_dly = 16'd0;
      k = cyc; pulse_rx();
      wait_until(k + 200);
      k = cyc; pulse_rx();
      expect_at(2 * D, 1'b0, 16'h0000, "R9 restarted not yet expired");
      expect_at(3 * D + 2, 1'b0, 16'h0001, "R9 expiry posts/R13");
      wait_until(k + 3 * D + 4);
      rd(2'd0, 16'h0010, "R9 receive cause bit");

      // R10: absolute receive delay ignores later events
      rx_pkt_dly = 16'd0; rx_abs_dly = 16'd3;
      k = cyc; pulse_rx();
      expect_at(2 * D, 1'b0, 16'h0000, "R10 before expiry");
      expect_at(3 * D + 2, 1'b0, 16'h0001, "R10 expiry from first event/R13");
      wait_until(k + 200);
      pulse_rx();
      wait_until(k + 3 * D + 4);
      rd(2'd0, 16'h0010, "R10 receive cause bit");
      step(4 * D);
      line(1'b0, "R10 no second expiry");

      // R11: transmit idle then absolute delay
      rx_abs_dly = 16'd0;
      tx_idle_dly = 16'd2;
      k = cyc; pulse_tx();
      expect_at(D, 1'b0, 16'h0000, "R11 idle before expiry");
      expect_at(2 * D + 2, 1'b0, 16'h0001, "R11 idle expiry posts");
      wait_until(k + 2 * D + 4);
      rd(2'd0, 16'h0001, "R11 transmit cause bit");
      tx_idle_dly = 16'd0; tx_abs_dly = 16'd2;
      k = cyc; pulse_tx();
      expect_at(D, 1'b0, 16'h0000, "R11 abs before expiry");
      expect_at(2 * D + 2, 1'b0, 16'h0001, "R11 abs expiry posts");
      wait_until(k + 2 * D + 4);
      rd(2'd0, 16'h0001, "R11 transmit cause abs");

      // R12: zero reloads disable timers
      tx_abs_dly = 16'd0;
      pulse_rx();
      pulse_tx();
      step(4 * D);
      line(1'b0, "R12 no expiry with zero reload");
      rd(2'd0, 16'h0000, "R12 nothing pending");

      step(4);
      while (sb.size() > 0) begin
         bad++; total++;
         $display("FAIL %s: actual=unchecked expected=checked", sb[0].tag);
         void'(sb.pop_front());
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule